// File: doc/BRIEF.md
# Two-Event Join with Restart

This block joins two independent event streams. Each clock cycle it samples a restart pulse and two event pulses, one carrying an address arrival (bit 0) and one carrying a data arrival (bit 1). The events may arrive in either order, with gaps, or together. The output pulse fires in the cycle when the last missing event arrives. The cycle is not delayed, because the output is combinational from the current inputs and the stored wait state.

After firing, the block stays idle until a restart pulse. The restart reopens the whole join, so both events must arrive again. A typical use is a memory-write handshake: the restart marks a new request, and the fire pulse issues the write once the address and the data have both been seen.

The wait for each event is held in its own single-bit register, built by a generate loop over a parameterised event count. One further register records that the join has completed. The restart acts as a strong abort and overrides everything else in its cycle.

Top module: `evtJoin`

## Requirements
- R1: After reset, `fire` is 0, and no event has been recorded. A single event on its own (bit 0 or bit 1 of `evtIn`) does not raise `fire`.
- R2: `fire` is 1 in the same cycle in which the last still-missing event arrives, provided `restart` is 0.
- R3: If both bits of `evtIn` are 1 in the same cycle while both are still awaited and `restart` is 0, `fire` is 1 in that cycle.
- R4: After a cycle with `fire` = 1, further events leave `fire` at 0 until a cycle with `restart` = 1.
- R5: In a cycle with `restart` = 1, `fire` is 0, and any event bits in that same cycle are discarded.
- R6: After each restart cycle, both events must arrive again (in later cycles) before `fire` rises.
- R7: An event that repeats while already recorded has no effect: `fire` still waits for the other event, and it fires once, in that event's cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset; leaves the block awaiting both events |
| restart | input | 1 | Abort-and-restart pulse; highest priority |
| evtIn | input | NUM_EVT (2) | Event pulses; bit 0 is the address event, bit 1 the data event |
| fire | output | 1 | Join-complete pulse, combinational in the arrival cycle |

## Verification
`fire` is due in the very cycle whose inputs complete the join, so each check drives the inputs just after a falling edge and samples `fire` shortly afterwards, before the next rising edge. The effect of a restart or of a recorded event shows up one rising edge later, in the stored state. The bench observes it only through `fire` in later cycles.

Expected values come from a flat four-state automaton kept in the bench (awaiting both, awaiting address, awaiting data, halted). This model is advanced at each rising edge. It is compared against an exhaustive sweep of every three-cycle input sequence from reset, followed by a long random run.

// File: rtl/evtJoin_pkg.sv
package evtJoin_pkg;

  // strobes from control to the wait-register datapath
  typedef struct packed {
    logic reload;   // re-arm every wait (restart)
    logic capture;  // clear waits for events seen this cycle
  } joinStrobe_t;

endpackage

// File: rtl/evtJoinWaits.sv
module evtJoinWaits
  import evtJoin_pkg::*;
#(
  parameter int NUM_EVT = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  joinStrobe_t        strobe,
  input  logic [NUM_EVT-1:0] evtIn,
  output logic               allSeen
);

  localparam logic [NUM_EVT-1:0] ALL_WAIT = {NUM_EVT{1'b1}};

  logic [NUM_EVT-1:0] waitReg;
  logic [NUM_EVT-1:0] stillWait;

  // one wait register per event
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_wait
    assign stillWait[i] = waitReg[i] & ~evtIn[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        waitReg[i] <= 1'b1;
      end else if (strobe.reload) begin
        waitReg[i] <= 1'b1;
      end else if (strobe.capture) begin
        waitReg[i] <= stillWait[i];
      end
    end
  end

  assign allSeen = (stillWait == '0);

  // a restart re-arms every wait
  AST_RELOAD_ARMS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reload |=> (waitReg == ALL_WAIT)); // R6

  // waits are only ever cleared, never set, outside a restart
  AST_WAIT_MONOTONE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.reload |=> ($countones(waitReg) <= $countones($past(waitReg)))); // R7

endmodule

// File: rtl/evtJoinCtrl.sv
module evtJoinCtrl
  import evtJoin_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        restart,
  input  logic        allSeen,
  output joinStrobe_t strobe,
  output logic        fire
);

  logic haltReg;

  always_comb begin
    strobe.reload  = restart;
    strobe.capture = !restart && !haltReg;
    fire           = !restart && !haltReg && allSeen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haltReg <= 1'b0;
    end else if (restart) begin
      haltReg <= 1'b0;
    end else if (fire) begin
      haltReg <= 1'b1;
    end
  end

  AST_NO_FIRE_ON_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    restart |-> !fire); // R5

  AST_SINGLE_FIRE: assert property (@(posedge clk) disable iff (!rstN)
    fire |=> !fire); // R4

  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (haltReg && !restart) |-> !fire); // R4

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.reload, strobe.capture})); // R5

endmodule

// File: rtl/evtJoin.sv
module evtJoin
  import evtJoin_pkg::*;
#(
  parameter int NUM_EVT = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               restart,
  input  logic [NUM_EVT-1:0] evtIn,
  output logic               fire
);

  joinStrobe_t strobe;
  logic        allSeen;

  evtJoinCtrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .restart(restart),
    .allSeen(allSeen),
    .strobe (strobe),
    .fire   (fire)
  );

  evtJoinWaits #(.NUM_EVT(NUM_EVT)) u_waits (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .evtIn  (evtIn),
    .allSeen(allSeen)
  );

endmodule

// File: tb/evtJoin_test.sv
module evtJoin_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       restart = 1'b0;
  logic [1:0] evtIn = 2'b00;
  logic       fire;

  int nChecks = 0;
  int nFails  = 0;

  // flat reference automaton state
  logic gotA, gotB, halted, afterRestart;

  always #10 clk = ~clk;

  evtJoin #(.NUM_EVT(2)) uut (
    .clk    (clk),
    .rstN   (rstN),
    .restart(restart),
    .evtIn  (evtIn),
    .fire   (fire)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: fire=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; restart = 1'b0; evtIn = 2'b00;
    @(negedge clk);
    rstN = 1'b1;
    gotA = 1'b0; gotB = 1'b0; halted = 1'b0; afterRestart = 1'b0;
  endtask

  // drive one cycle, compare, advance the model at the rising edge
  task automatic step(input logic r, input logic a, input logic b);
    logic  expFire;
    string tag;
    @(negedge clk);
    restart = r; evtIn = {b, a};
    expFire = !r && !halted && (gotA || a) && (gotB || b);
    if (r)                                   tag = "R5";
    else if (halted)                         tag = "R4";
    else if (!gotA && !gotB && a && b)       tag = "R3";
    else if (afterRestart)                   tag = "R6";
    else if ((gotA && a) || (gotB && b))     tag = "R7";
    else if (expFire)                        tag = "R2";
    else                                     tag = "R1";
    #3;
    check(tag, fire, expFire);
    @(posedge clk);
    if (r) begin
      gotA = 1'b0; gotB = 1'b0; halted = 1'b0; afterRestart = 1'b1;
    end else if (!halted) begin
      if (expFire) begin
        halted = 1'b1; gotA = 1'b0; gotB = 1'b0;
      end else begin
        gotA = gotA || a; gotB = gotB || b;
      end
      afterRestart = 1'b0;
    end else begin
      afterRestart = 1'b0;
    end
  endtask

  initial begin : watchdog
    #(20 * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    doReset();
    // R1: reset state, then a lone address event
    #3; check("R1", fire, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1);   // R2 completes
    step(1'b0, 1'b1, 1'b1);   // R4 ignored
    step(1'b1, 1'b1, 1'b1);   // R5 restart wins
    step(1'b0, 1'b0, 1'b1);   // R6 data alone
    step(1'b0, 1'b0, 1'b1);   // R7 repeat
    step(1'b0, 1'b1, 1'b0);   // R2 fires

    // exhaustive: every 3-cycle sequence of the 8 input combinations
    for (int seq = 0; seq < 512; seq++) begin
      doReset();
      for (int k = 0; k < 3; k++) begin
        int c;
        c = (seq >> (3 * k)) & 7;
        step(c[2], c[0], c[1]);
      end
    end

    // long random run, restarts kept sparse
    doReset();
    for (int n = 0; n < 4000; n++) begin
      int rv;
      rv = $urandom_range(0, 15);
      step(rv == 0, $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule